// File: doc/BRIEF.md
# In-Order Pipeline Interlock Unit

This unit decides, one instruction at a time, when a single-issue in-order pipeline may issue. Each cycle it is offered one pre-decoded instruction on a valid/ready stream. The instruction carries a class, an optional destination register, and up to two source registers. Each register is tagged as belonging to the integer file or to the floating-point file. The unit keeps a per-register record of results that are still in flight. It holds the instruction back (ready low, stall high) until every read-after-write dependence on those results has aged enough. The required wait depends on both the class of the producer and the role of the consumer.

Back-pressure rules: an instruction issues in the cycle where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the sender must hold the instruction and all of its fields unchanged. `in_ready` is computed from the fields currently presented. The unit also exposes a free-running cycle counter, a running total of stall cycles, and a flag that marks the instruction issued directly after a branch, which is the branch delay slot.

Top module: `ilk_interlock`

## Requirements
- R1: An instruction issues (`iss_fire`) exactly when `in_valid` and `in_ready` are high. `stall` is high when `in_valid` is high and `in_ready` is low. Class codes on `in_kind` are: 0 load, 1 store, 2 FP add, 3 FP multiply, 4 integer ALU, 5 branch. For a store, `in_sb` is the data to write and `in_sa` is the address base. Register file tags are 0 for integer and 1 for FP.
- R2: A consumer of a load result issues no earlier than 2 cycles after the load, which is 1 stall cycle.
- R3: A consumer of an FP add result issues 4 cycles after it (3 stalls), unless it is the case in R4.
- R4: A store whose data operand comes from an FP add waits 2 stall cycles. If the data operand comes from an FP multiply, it waits 4 stall cycles.
- R5: A consumer of an FP multiply result waits 5 stall cycles, unless it is the case in R4.
- R6: A branch that reads an integer ALU result waits 1 stall cycle. Every other consumer of an integer ALU result waits none.
- R7: A source matches a pending result only if both the register number and the file tag are equal.
- R8: A store's base operand follows the general latency of its producer, not the store-data latency.
- R9: Write-after-read reuse never stalls. A dependence whose latency has already elapsed, through independent instructions in between, does not stall.
- R10: A destination presented with a store or a branch is ignored and creates no pending result.
- R11: `iss_slot` is high together with `iss_fire` for the instruction issued directly after a branch, and is low for every other issue.
- R12: `cycle_now` is 0 during reset and rises by 1 on every clock after it. `stall_total` is 0 after reset and rises by 1 in each cycle with `stall` high.
- R13: A synchronous reset clears all pending results, so the first instruction after reset issues without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_kind | input | 3 | Instruction class code |
| in_dst | input | RW | Destination register number |
| in_dst_en | input | 1 | Destination is written |
| in_dst_fp | input | 1 | Destination file tag |
| in_sa | input | RW | Source A register (store base) |
| in_sa_en | input | 1 | Source A is read |
| in_sa_fp | input | 1 | Source A file tag |
| in_sb | input | RW | Source B register (store data) |
| in_sb_en | input | 1 | Source B is read |
| in_sb_fp | input | 1 | Source B file tag |
| stall | output | 1 | Presented instruction held this cycle |
| iss_fire | output | 1 | Presented instruction issues this cycle |
| iss_slot | output | 1 | Issuing instruction sits in a branch delay slot |
| cycle_now | output | CW | Cycle count since reset |
| stall_total | output | CW | Stall cycles since reset |

## Verification
The assertions assume that a held instruction keeps its class and register fields stable until it issues, and one property checks this assumption directly. The bench drives each instruction on a falling edge and leaves every field untouched until the unit accepts it. It then drops `in_valid` just after the accepting edge, so instructions follow back to back and never change while held. The assertions also assume that only the six class codes are presented, and the bench uses no other codes.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_STORE  = 3'd1,
    K_FADD   = 3'd2,
    K_FMUL   = 3'd3,
    K_IALU   = 3'd4,
    K_BRANCH = 3'd5
  } kind_e;

  function automatic logic kind_writes(kind_e k);
    return (k == K_LOAD) || (k == K_FADD) || (k == K_FMUL) || (k == K_IALU);
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int RW      = 5,
  parameter int AW      = 3,
  parameter int AGE_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_fp,
  input  logic [RW-1:0] wr_idx,
  input  kind_e         wr_kind,
  input  logic          rd_fp   [2],
  input  logic [RW-1:0] rd_idx  [2],
  output logic          rd_busy [2],
  output kind_e         rd_kind [2],
  output logic [AW-1:0] rd_age  [2]
);

  localparam int NENT = 2 * NREG;

  logic          busy_v [NENT];
  kind_e         kind_v [NENT];
  logic [AW-1:0] age_v  [NENT];

  for (genvar f = 0; f < 2; f++) begin : g_file
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic          busy_q;
      kind_e         kind_q;
      logic [AW-1:0] age_q;
      logic          hit;

      assign hit = wr_en && (wr_fp == 1'(f)) && (wr_idx == RW'(r));

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q <= 1'b0;
          kind_q <= K_LOAD;
          age_q  <= '0;
        end else if (hit) begin
          busy_q <= 1'b1;
          kind_q <= wr_kind;
          age_q  <= AW'(1);
        end else if (busy_q && (age_q != AW'(AGE_MAX))) begin
          age_q  <= age_q + AW'(1);
        end
      end

      assign busy_v[f*NREG + r] = busy_q;
      assign kind_v[f*NREG + r] = kind_q;
      assign age_v [f*NREG + r] = age_q;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    int sel;
    always_comb begin
      sel        = (rd_fp[p] ? NREG : 0) + int'(rd_idx[p]);
      rd_busy[p] = busy_v[sel];
      rd_kind[p] = kind_v[sel];
      rd_age[p]  = age_v[sel];
    end
  end

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int AW          = 3,
  parameter int LAT_LD      = 1,
  parameter int LAT_FADD    = 3,
  parameter int LAT_FADD_ST = 2,
  parameter int LAT_FMUL    = 5,
  parameter int LAT_FMUL_ST = 4,
  parameter int LAT_IALU_BR = 1
) (
  input  kind_e         cons_kind,
  input  logic          src_en   [2],
  input  logic          src_busy [2],
  input  kind_e         src_kind [2],
  input  logic [AW-1:0] src_age  [2],
  output logic          blocked
);

  // Stall cycles owed by a consumer to a producer of class prod.
  function automatic logic [AW-1:0] gap(kind_e prod, kind_e cons, logic is_data);
    case (prod)
      K_LOAD: return AW'(LAT_LD);
      K_FADD: return is_data ? AW'(LAT_FADD_ST) : AW'(LAT_FADD);
      K_FMUL: return is_data ? AW'(LAT_FMUL_ST) : AW'(LAT_FMUL);
      K_IALU: return (cons == K_BRANCH) ? AW'(LAT_IALU_BR) : '0;
      default: return '0;
    endcase
  endfunction

  logic blk [2];

  for (genvar p = 0; p < 2; p++) begin : g_src
    logic is_data;
    assign is_data = (p == 1) && (cons_kind == K_STORE);
    assign blk[p]  = src_en[p] && src_busy[p] &&
                     (src_age[p] <= gap(src_kind[p], cons_kind, is_data));
  end

  assign blocked = blk[0] || blk[1];

endmodule

// File: rtl/ilk_counters.sv
module ilk_counters #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          fire,
  input  logic          fire_branch,
  output logic [CW-1:0] cycle_now,
  output logic [CW-1:0] stall_total,
  output logic          slot
);

  logic after_branch;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_now    <= '0;
      stall_total  <= '0;
      after_branch <= 1'b0;
    end else begin
      cycle_now <= cycle_now + CW'(1);
      if (stall) stall_total <= stall_total + CW'(1);
      if (fire)  after_branch <= fire_branch;
    end
  end

  assign slot = fire && after_branch;

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int CW          = 32,
  parameter int LAT_LD      = 1,
  parameter int LAT_FADD    = 3,
  parameter int LAT_FADD_ST = 2,
  parameter int LAT_FMUL    = 5,
  parameter int LAT_FMUL_ST = 4,
  parameter int LAT_IALU_BR = 1,
  localparam int RW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_kind,
  input  logic [RW-1:0] in_dst,
  input  logic          in_dst_en,
  input  logic          in_dst_fp,
  input  logic [RW-1:0] in_sa,
  input  logic          in_sa_en,
  input  logic          in_sa_fp,
  input  logic [RW-1:0] in_sb,
  input  logic          in_sb_en,
  input  logic          in_sb_fp,
  output logic          stall,
  output logic          iss_fire,
  output logic          iss_slot,
  output logic [CW-1:0] cycle_now,
  output logic [CW-1:0] stall_total
);

  localparam int M1      = (LAT_FADD > LAT_FMUL) ? LAT_FADD : LAT_FMUL;
  localparam int M2      = (LAT_LD > LAT_IALU_BR) ? LAT_LD : LAT_IALU_BR;
  localparam int MAXLAT  = (M1 > M2) ? M1 : M2;
  localparam int AGE_MAX = MAXLAT + 1;
  localparam int AW      = $clog2(AGE_MAX + 1);

  kind_e         kind;
  logic          blocked;
  logic          wr_en;
  logic          rd_fp   [2];
  logic [RW-1:0] rd_idx  [2];
  logic          src_en  [2];
  logic          rd_busy [2];
  kind_e         rd_kind [2];
  logic [AW-1:0] rd_age  [2];

  assign kind      = kind_e'(in_kind);
  assign rd_fp[0]  = in_sa_fp;
  assign rd_fp[1]  = in_sb_fp;
  assign rd_idx[0] = in_sa;
  assign rd_idx[1] = in_sb;
  assign src_en[0] = in_sa_en;
  assign src_en[1] = in_sb_en;

  assign in_ready = !blocked;
  assign stall    = in_valid && blocked;
  assign iss_fire = in_valid && !blocked;
  assign wr_en    = iss_fire && in_dst_en && kind_writes(kind);

  ilk_scoreboard #(
    .NREG(NREG), .RW(RW), .AW(AW), .AGE_MAX(AGE_MAX)
  ) sb_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_fp(in_dst_fp), .wr_idx(in_dst), .wr_kind(kind),
    .rd_fp(rd_fp), .rd_idx(rd_idx),
    .rd_busy(rd_busy), .rd_kind(rd_kind), .rd_age(rd_age)
  );

  ilk_hazard #(
    .AW(AW), .LAT_LD(LAT_LD), .LAT_FADD(LAT_FADD), .LAT_FADD_ST(LAT_FADD_ST),
    .LAT_FMUL(LAT_FMUL), .LAT_FMUL_ST(LAT_FMUL_ST), .LAT_IALU_BR(LAT_IALU_BR)
  ) hz_i (
    .cons_kind(kind), .src_en(src_en), .src_busy(rd_busy),
    .src_kind(rd_kind), .src_age(rd_age), .blocked(blocked)
  );

  ilk_counters #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .stall(stall), .fire(iss_fire),
    .fire_branch(kind == K_BRANCH),
    .cycle_now(cycle_now), .stall_total(stall_total), .slot(iss_slot)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int RW = 5,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_kind,
  input logic [RW-1:0] in_dst,
  input logic          in_dst_en,
  input logic          in_dst_fp,
  input logic [RW-1:0] in_sa,
  input logic          in_sa_en,
  input logic          in_sa_fp,
  input logic [RW-1:0] in_sb,
  input logic          iss_fire,
  input logic          iss_slot,
  input logic          stall,
  input logic [CW-1:0] cycle_now,
  input logic [CW-1:0] stall_total
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |=> in_valid && $stable(in_kind) && $stable(in_sa) && $stable(in_sb)); // R1

  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (rst)
    iss_fire && (in_kind == 3'd0) && in_dst_en
    |=> !(iss_fire && in_sa_en && (in_sa == $past(in_dst)) && (in_sa_fp == $past(in_dst_fp)))); // R2

  AST_SLOT_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
    iss_slot |-> iss_fire); // R11

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycle_now == $past(cycle_now) + CW'(1)); // R12

  AST_STALL_SUM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stall_total == $past(stall_total) + CW'($past(stall))); // R12

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && in_valid |-> in_ready); // R13

endmodule

bind ilk_interlock ilk_checker #(.RW(RW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_dst(in_dst), .in_dst_en(in_dst_en), .in_dst_fp(in_dst_fp),
  .in_sa(in_sa), .in_sa_en(in_sa_en), .in_sa_fp(in_sa_fp), .in_sb(in_sb),
  .iss_fire(iss_fire), .iss_slot(iss_slot), .stall(stall),
  .cycle_now(cycle_now), .stall_total(stall_total)
);

// File: tb/ilk_interlock_tb_top.sv
module ilk_interlock_tb_top;

  localparam int KLD = 0, KST = 1, KFA = 2, KFM = 3, KIA = 4, KBR = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [4:0]  in_dst = '0, in_sa = '0, in_sb = '0;
  logic        in_dst_en = 1'b0, in_dst_fp = 1'b0;
  logic        in_sa_en = 1'b0, in_sa_fp = 1'b0, in_sb_en = 1'b0, in_sb_fp = 1'b0;
  logic        stall, iss_fire, iss_slot;
  logic [31:0] cycle_now, stall_total;

  int n_chk = 0, n_bad = 0;
  int last_cyc, last_slot, base_cyc, base_stall;
  bit finished = 0;

  always #10 clk = ~clk;

  ilk_interlock dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_dst(in_dst), .in_dst_en(in_dst_en), .in_dst_fp(in_dst_fp),
    .in_sa(in_sa), .in_sa_en(in_sa_en), .in_sa_fp(in_sa_fp),
    .in_sb(in_sb), .in_sb_en(in_sb_en), .in_sb_fp(in_sb_fp),
    .stall(stall), .iss_fire(iss_fire), .iss_slot(iss_slot),
    .cycle_now(cycle_now), .stall_total(stall_total)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Present one instruction, wait for acceptance, record issue cycle and slot flag.
  task automatic send(int k, int d, int dfp, int den, int a, int afp, int aen,
                      int b, int bfp, int ben);
    @(negedge clk);
    in_kind = 3'(k); in_dst = 5'(d); in_dst_fp = 1'(dfp); in_dst_en = 1'(den);
    in_sa = 5'(a); in_sa_fp = 1'(afp); in_sa_en = 1'(aen);
    in_sb = 5'(b); in_sb_fp = 1'(bfp); in_sb_en = 1'(ben);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      if (!(stall === 1'b1 && iss_fire === 1'b0)) chk("R1 stall while held", 0, 1);
      @(negedge clk);
      #1;
    end
    if (!(iss_fire === 1'b1 && stall === 1'b0)) chk("R1 fire when ready", 0, 1);
    last_cyc  = int'(cycle_now);
    last_slot = int'(iss_slot);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic mark();
    base_cyc   = last_cyc;
    base_stall = int'(stall_total);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R12 cycle after reset", int'(cycle_now), 0);
    chk("R12 stalls after reset", int'(stall_total), 0);
    chk("R1 no fire when idle", int'(iss_fire), 0);
    send(KLD, 0, 1, 1, 1, 0, 1, 0, 0, 0);
    do_reset();
    send(KFA, 4, 1, 1, 0, 1, 1, 2, 1, 1);
    chk("R13 first issue after reset", last_cyc, 1);
    chk("R13 no stall after reset", int'(stall_total), 0);
  endtask

  task automatic t_load();
    do_reset();
    send(KLD, 0, 1, 1, 1, 0, 1, 0, 0, 0); mark();
    send(KFA, 4, 1, 1, 0, 1, 1, 2, 1, 1);
    chk("R2 load to add", last_cyc - base_cyc, 2);
    chk("R12 stall total load", int'(stall_total) - base_stall, 1);
    send(KLD, 6, 1, 1, 1, 0, 1, 0, 0, 0); mark();
    send(KIA, 9, 0, 1, 1, 0, 1, 2, 0, 1);
    send(KFA, 8, 1, 1, 6, 1, 1, 2, 1, 1);
    chk("R9 elapsed load dependence", last_cyc - base_cyc, 2);
    chk("R9 no stall elapsed", int'(stall_total) - base_stall, 0);
  endtask

  task automatic t_fadd();
    do_reset();
    send(KFA, 4, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KFA, 6, 1, 1, 4, 1, 1, 2, 1, 1);
    chk("R3 add to add", last_cyc - base_cyc, 4);
    send(KFA, 10, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KST, 0, 0, 0, 1, 0, 1, 10, 1, 1);
    chk("R4 add to store data", last_cyc - base_cyc, 3);
    chk("R12 stall total store", int'(stall_total) - base_stall, 2);
  endtask

  task automatic t_fmul();
    do_reset();
    send(KFM, 4, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KST, 0, 0, 0, 2, 0, 1, 4, 1, 1);
    chk("R4 mul to store data", last_cyc - base_cyc, 5);
    send(KFM, 8, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KFA, 10, 1, 1, 8, 1, 1, 2, 1, 1);
    chk("R5 mul to add", last_cyc - base_cyc, 6);
    chk("R12 stall total mul", int'(stall_total) - base_stall, 5);
    send(KFM, 12, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KST, 0, 0, 0, 12, 1, 1, 0, 1, 1);
    chk("R8 store base from mul", last_cyc - base_cyc, 6);
  endtask

  task automatic t_int();
    do_reset();
    send(KIA, 1, 0, 1, 2, 0, 1, 3, 0, 1); mark();
    send(KBR, 0, 0, 0, 1, 0, 1, 2, 0, 1);
    chk("R6 ialu to branch", last_cyc - base_cyc, 2);
    send(KIA, 3, 0, 1, 2, 0, 1, 4, 0, 1); mark();
    send(KLD, 0, 1, 1, 3, 0, 1, 0, 0, 0);
    chk("R6 ialu to load", last_cyc - base_cyc, 1);
    send(KLD, 5, 0, 1, 2, 0, 1, 0, 0, 0); mark();
    send(KST, 0, 0, 0, 5, 0, 1, 0, 1, 1);
    chk("R8 store base from load", last_cyc - base_cyc, 2);
  endtask

  task automatic t_file();
    do_reset();
    send(KLD, 3, 1, 1, 1, 0, 1, 0, 0, 0); mark();
    send(KIA, 7, 0, 1, 3, 0, 1, 3, 0, 1);
    chk("R7 fp load vs int source", last_cyc - base_cyc, 1);
    send(KFM, 2, 1, 1, 0, 1, 1, 1, 1, 1); mark();
    send(KBR, 0, 0, 0, 2, 0, 1, 2, 0, 1);
    chk("R7 fp mul vs int branch", last_cyc - base_cyc, 1);
  endtask

  task automatic t_war();
    do_reset();
    send(KFA, 4, 1, 1, 0, 1, 1, 2, 1, 1); mark();
    send(KLD, 0, 1, 1, 1, 0, 1, 0, 0, 0);
    chk("R9 write after read", last_cyc - base_cyc, 1);
    send(KIA, 6, 0, 1, 7, 0, 1, 8, 0, 1); mark();
    send(KIA, 7, 0, 1, 9, 0, 1, 9, 0, 1);
    chk("R9 int write after read", last_cyc - base_cyc, 1);
  endtask

  task automatic t_ignored();
    do_reset();
    send(KST, 4, 1, 1, 1, 0, 1, 0, 1, 1); mark();
    send(KFA, 6, 1, 1, 4, 1, 1, 4, 1, 1);
    chk("R10 store dest ignored", last_cyc - base_cyc, 1);
    send(KBR, 1, 0, 1, 2, 0, 1, 3, 0, 1); mark();
    send(KBR, 0, 0, 0, 1, 0, 1, 1, 0, 1);
    chk("R10 branch dest ignored", last_cyc - base_cyc, 1);
    chk("R10 no stalls", int'(stall_total) - base_stall, 0);
  endtask

  task automatic t_slot();
    do_reset();
    send(KIA, 1, 0, 1, 2, 0, 1, 3, 0, 1);
    chk("R11 plain issue", last_slot, 0);
    send(KBR, 0, 0, 0, 1, 0, 1, 2, 0, 1);
    chk("R11 branch not slot", last_slot, 0);
    send(KIA, 4, 0, 1, 2, 0, 1, 3, 0, 1);
    chk("R11 delay slot flagged", last_slot, 1);
    send(KIA, 5, 0, 1, 2, 0, 1, 3, 0, 1);
    chk("R11 after slot", last_slot, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_fadd();
    t_fmul();
    t_int();
    t_file();
    t_war();
    t_ignored();
    t_slot();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule